// File: doc/BRIEF.md
# UART Interrupt Prioritizer and FIFO Event Generator

This block merges the status conditions of a 16550-style serial port into one interrupt request and a four-bit identification code. Only the highest-priority pending cause is reported. The sources are sticky line errors, receive data available, a receive character timeout and an empty transmit holding stage. Software drives three side-effect strobes: reading the identification code, reading the line status, and writing the transmit holding register. These strobes clear or re-arm individual causes.

The block also holds the FIFO control settings. These are written through an 8-bit control write that shares its address with the identification read. The settings select FIFO operation, the receive trigger depth and a DMA mode. The write can also request one-cycle flush pulses for either FIFO. When FIFO operation and DMA mode are both on, the block emits single-cycle DMA request pulses. The receive request fires when the trigger depth is met or a timeout occurs. The transmit request fires when the transmit side goes empty. FIFO storage, the baud timing and the shift engines sit outside this block. They supply the receive fill count, the push and pop strobes and a once-per-character tick.

Top module: `uart_irq_prio`

## Requirements
- R1: The identification output reports the highest pending enabled cause in this order: line error (0110), then receive data available (0100), then character timeout (1100), then transmitter empty (0010). When nothing is pending it reads 0001.
- R2: `irq` is high exactly when the identification output differs from 0001.
- R3: Each cause reaches `irq` and the identification output only while its enable is set. `ie_line` gates line errors, `ie_rx` gates data available and timeout, and `ie_tx` gates transmitter empty.
- R4: Any bit of `line_err_set` latches a line-error flag. The flag stays set after the pulse ends and is cleared by `lsr_rd` in a cycle with no new error.
- R5: Receive data is available when `rx_count` is at least one in non-FIFO mode. In FIFO mode it must reach the trigger depth chosen by control bits 7:6: 00=1, 01=4, 10=8, 11=14.
- R6: In FIFO mode with a non-empty receive FIFO, a timeout is raised on the 4th `char_tick` with no `rx_push` or `rx_pop` since the last such strobe. A push, a pop or an empty FIFO clears the timeout and restarts the count.
- R7: An `iir_rd` while transmitter empty is the reported cause suppresses that cause. It stays suppressed until `thr_wr` or until `thr_empty` falls. An `iir_rd` while another cause is reported leaves transmitter empty pending.
- R8: A control write (`fcr_wr`) loads FIFO enable from bit 0, DMA mode from bit 3 and trigger select from bits 7:6. In the following cycle it raises `rx_fifo_clr` if bit 1 was set and `tx_fifo_clr` if bit 2 was set, each for one cycle.
- R9: With FIFO enable and DMA mode both set, `rx_dma_evt` pulses for one cycle after data available or timeout rises. `tx_dma_evt` pulses for one cycle after `thr_empty` rises. With DMA mode clear, neither pulses.
- R10: After reset, `irq` is low, the identification output is 0001, all pulse outputs are low, and FIFO mode and DMA mode are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ie_line | input | 1 | Enable for line-error cause |
| ie_rx | input | 1 | Enable for data-available and timeout causes |
| ie_tx | input | 1 | Enable for transmitter-empty cause |
| line_err_set | input | 4 | Error strobes (overrun, parity, framing, break), any bit sets the flag |
| lsr_rd | input | 1 | Line status read strobe |
| iir_rd | input | 1 | Identification read strobe |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_data | input | 8 | FIFO control write data |
| rx_count | input | CNT_W | Characters waiting in the receive FIFO |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_pop | input | 1 | A character was read from the receive FIFO |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Transmit holding stage or FIFO is empty |
| thr_wr | input | 1 | Transmit holding write strobe |
| irq | output | 1 | Interrupt request |
| iir_id | output | 4 | Identification code of the reported cause |
| rx_fifo_clr | output | 1 | Receive FIFO flush pulse |
| tx_fifo_clr | output | 1 | Transmit FIFO flush pulse |
| rx_dma_evt | output | 1 | Receive DMA request pulse |
| tx_dma_evt | output | 1 | Transmit DMA request pulse |

## Verification
The bench targets the trigger-depth edges: a count one below each threshold versus the threshold itself. A design with the depth table shifted would report data available a character early or late. It checks that a line error outranks everything, and that identification reads clear transmitter empty only when it is the reported cause. A design that cleared it on every read would lose a transmit interrupt behind a line error. The timeout is probed at the third and fourth tick and across an intervening push. An off-by-one counter, or one that ignores the push, fires at the wrong tick. The DMA pulses are checked to last one cycle and to stay silent with DMA mode off.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   typedef enum logic [3:0] {
      IID_NONE = 4'b0001,
      IID_LINE = 4'b0110,
      IID_RDAT = 4'b0100,
      IID_TOUT = 4'b1100,
      IID_TXMT = 4'b0010
   } iid_e;

   // receive trigger depth from the two-bit select
   function automatic int unsigned trig_depth(input logic [1:0] sel);
      case (sel)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 8;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/uirq_fcr_reg.sv
module uirq_fcr_reg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] data,
   output logic       fifo_en,
   output logic       dma_mode,
   output logic [1:0] trig_sel,
   output logic       rx_clr,
   output logic       tx_clr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_en  <= 1'b0;
         dma_mode <= 1'b0;
         trig_sel <= 2'b00;
         rx_clr   <= 1'b0;
         tx_clr   <= 1'b0;
      end else begin
         rx_clr <= wr & data[1];
         tx_clr <= wr & data[2];
         if (wr) begin
            fifo_en  <= data[0];
            dma_mode <= data[3];
            trig_sel <= data[7:6];
         end
      end
   end
endmodule

// File: rtl/uirq_timeout.sv
module uirq_timeout #(
   parameter int CNT_W    = 5,
   parameter int TO_CHARS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic             char_tick,
   output logic             timeout
);
   localparam int TO_W = (TO_CHARS > 1) ? $clog2(TO_CHARS) : 1;
   localparam logic [TO_W-1:0] LAST = TO_W'(TO_CHARS - 1);

   logic [TO_W-1:0] ticks;
   logic            restart;

   assign restart = !enable || (rx_count == '0) || rx_push || rx_pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks   <= '0;
         timeout <= 1'b0;
      end else if (restart) begin
         ticks   <= '0;
         timeout <= 1'b0;
      end else if (char_tick && !timeout) begin
         if (ticks == LAST) begin
            ticks   <= '0;
            timeout <= 1'b1;
         end else begin
            ticks <= ticks + 1'b1;
         end
      end
   end
endmodule

// File: rtl/uirq_encoder.sv
module uirq_encoder
   import uart_irq_pkg::*;
(
   input  logic src_line,
   input  logic src_rdat,
   input  logic src_tout,
   input  logic src_txmt,
   output iid_e id
);
   always_comb begin
      if (src_line)      id = IID_LINE;
      else if (src_rdat) id = IID_RDAT;
      else if (src_tout) id = IID_TOUT;
      else if (src_txmt) id = IID_TXMT;
      else               id = IID_NONE;
   end
endmodule

// File: rtl/uirq_edge_pulse.sv
module uirq_edge_pulse #(
   parameter int NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] cond,
   output logic [NUM-1:0] pulse
);
   for (genvar g = 0; g < NUM; g++) begin : g_chan
      logic seen;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seen     <= 1'b0;
            pulse[g] <= 1'b0;
         end else begin
            seen     <= cond[g];
            pulse[g] <= cond[g] & ~seen;
         end
      end
   end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int CNT_W    = 5,
   parameter int TO_CHARS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ie_line,
   input  logic             ie_rx,
   input  logic             ie_tx,
   input  logic [3:0]       line_err_set,
   input  logic             lsr_rd,
   input  logic             iir_rd,
   input  logic             fcr_wr,
   input  logic [7:0]       fcr_data,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic             char_tick,
   input  logic             thr_empty,
   input  logic             thr_wr,
   output logic             irq,
   output logic [3:0]       iir_id,
   output logic             rx_fifo_clr,
   output logic             tx_fifo_clr,
   output logic             rx_dma_evt,
   output logic             tx_dma_evt
);
   if (CNT_W < 4) begin : g_bad_cnt
      $error("CNT_W must hold a count of at least 14");
   end
   if (TO_CHARS < 1) begin : g_bad_to
      $error("TO_CHARS must be positive");
   end

   logic       fifo_en, dma_mode;
   logic [1:0] trig_sel;
   logic       line_flag, txmt_ack, tout;
   logic       rdat_lvl;
   logic       src_line, src_rdat, src_tout, src_txmt;
   logic [1:0] evt_cond, evt_pulse;
   iid_e       id;

   uirq_fcr_reg u_fcr (
      .clk(clk), .rst_n(rst_n), .wr(fcr_wr), .data(fcr_data),
      .fifo_en(fifo_en), .dma_mode(dma_mode), .trig_sel(trig_sel),
      .rx_clr(rx_fifo_clr), .tx_clr(tx_fifo_clr)
   );

   uirq_timeout #(.CNT_W(CNT_W), .TO_CHARS(TO_CHARS)) u_tout (
      .clk(clk), .rst_n(rst_n), .enable(fifo_en), .rx_count(rx_count),
      .rx_push(rx_push), .rx_pop(rx_pop), .char_tick(char_tick),
      .timeout(tout)
   );

   // sticky line-error flag: a new error wins over a same-cycle read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              line_flag <= 1'b0;
      else if (|line_err_set)  line_flag <= 1'b1;
      else if (lsr_rd)         line_flag <= 1'b0;
   end

   // transmitter-empty acknowledge set by an identification read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         txmt_ack <= 1'b0;
      else if (thr_wr || !thr_empty)      txmt_ack <= 1'b0;
      else if (iir_rd && id == IID_TXMT)  txmt_ack <= 1'b1;
   end

   always_comb begin
      if (fifo_en) rdat_lvl = int'(rx_count) >= int'(trig_depth(trig_sel));
      else         rdat_lvl = rx_count != '0;
   end

   assign src_line = ie_line & line_flag;
   assign src_rdat = ie_rx & rdat_lvl;
   assign src_tout = ie_rx & tout;
   assign src_txmt = ie_tx & thr_empty & ~txmt_ack;

   uirq_encoder u_enc (
      .src_line(src_line), .src_rdat(src_rdat), .src_tout(src_tout),
      .src_txmt(src_txmt), .id(id)
   );

   assign iir_id = id;
   assign irq    = src_line | src_rdat | src_tout | src_txmt;

   assign evt_cond[0] = fifo_en & dma_mode & (rdat_lvl | tout);
   assign evt_cond[1] = fifo_en & dma_mode & thr_empty;

   uirq_edge_pulse #(.NUM(2)) u_evt (
      .clk(clk), .rst_n(rst_n), .cond(evt_cond), .pulse(evt_pulse)
   );

   assign rx_dma_evt = evt_pulse[0];
   assign tx_dma_evt = evt_pulse[1];
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] line_err_set,
   input logic       lsr_rd,
   input logic       iir_rd,
   input logic       fcr_wr,
   input logic [7:0] fcr_data,
   input logic       thr_wr,
   input logic       thr_empty,
   input logic       irq,
   input logic [3:0] iir_id,
   input logic       rx_fifo_clr,
   input logic       tx_fifo_clr,
   input logic       rx_dma_evt,
   input logic       tx_dma_evt
);
   AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (iir_id != 4'b0001)); // R2
   AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      iir_id inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010}); // R1
   AST_LINE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && line_err_set == 4'b0) |=> iir_id != 4'b0110); // R4
   AST_TXMT_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && iir_id == 4'b0010 && !thr_wr && thr_empty) |=> iir_id != 4'b0010); // R7
   AST_RX_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (fcr_wr && fcr_data[1]) |=> rx_fifo_clr); // R8
   AST_TX_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (fcr_wr && fcr_data[2]) |=> tx_fifo_clr); // R8
   AST_RX_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dma_evt |=> !rx_dma_evt); // R9
   AST_TX_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dma_evt |=> !tx_dma_evt); // R9
endmodule

bind uart_irq_prio uart_irq_prio_chk u_chk (
   .clk(clk), .rst_n(rst_n), .line_err_set(line_err_set), .lsr_rd(lsr_rd),
   .iir_rd(iir_rd), .fcr_wr(fcr_wr), .fcr_data(fcr_data), .thr_wr(thr_wr),
   .thr_empty(thr_empty), .irq(irq), .iir_id(iir_id),
   .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr),
   .rx_dma_evt(rx_dma_evt), .tx_dma_evt(tx_dma_evt)
);

// File: tb/uart_irq_prio_test.sv
`timescale 1ns/1ps
module uart_irq_prio_test;
   localparam int CNT_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ie_line = 0, ie_rx = 0, ie_tx = 0;
   logic [3:0]       line_err_set = '0;
   logic             lsr_rd = 0, iir_rd = 0, fcr_wr = 0;
   logic [7:0]       fcr_data = '0;
   logic [CNT_W-1:0] rx_count = '0;
   logic             rx_push = 0, rx_pop = 0, char_tick = 0;
   logic             thr_empty = 0, thr_wr = 0;
   logic             irq;
   logic [3:0]       iir_id;
   logic             rx_fifo_clr, tx_fifo_clr, rx_dma_evt, tx_dma_evt;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   uart_irq_prio #(.CNT_W(CNT_W), .TO_CHARS(4)) uut (
      .clk(clk), .rst_n(rst_n), .ie_line(ie_line), .ie_rx(ie_rx),
      .ie_tx(ie_tx), .line_err_set(line_err_set), .lsr_rd(lsr_rd),
      .iir_rd(iir_rd), .fcr_wr(fcr_wr), .fcr_data(fcr_data),
      .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop),
      .char_tick(char_tick), .thr_empty(thr_empty), .thr_wr(thr_wr),
      .irq(irq), .iir_id(iir_id), .rx_fifo_clr(rx_fifo_clr),
      .tx_fifo_clr(tx_fifo_clr), .rx_dma_evt(rx_dma_evt),
      .tx_dma_evt(tx_dma_evt)
   );

   // fields: en[16:14] {line,rx,tx}, err[13], cnt[12:8], thre[7], fen[6], trig[5:4], exp[3:0]
   localparam logic [16:0] VEC [12] = '{
      {3'b000, 1'b1, 5'd5,  1'b1, 1'b1, 2'b00, 4'b0001},
      {3'b111, 1'b1, 5'd5,  1'b1, 1'b1, 2'b00, 4'b0110},
      {3'b111, 1'b0, 5'd5,  1'b1, 1'b1, 2'b00, 4'b0100},
      {3'b111, 1'b0, 5'd0,  1'b1, 1'b1, 2'b00, 4'b0010},
      {3'b111, 1'b0, 5'd3,  1'b1, 1'b1, 2'b01, 4'b0010},
      {3'b111, 1'b0, 5'd4,  1'b0, 1'b1, 2'b01, 4'b0100},
      {3'b111, 1'b0, 5'd7,  1'b0, 1'b1, 2'b10, 4'b0001},
      {3'b111, 1'b0, 5'd14, 1'b0, 1'b1, 2'b11, 4'b0100},
      {3'b111, 1'b0, 5'd13, 1'b0, 1'b1, 2'b11, 4'b0001},
      {3'b111, 1'b0, 5'd1,  1'b0, 1'b0, 2'b11, 4'b0100},
      {3'b011, 1'b1, 5'd0,  1'b1, 1'b0, 2'b00, 4'b0010},
      {3'b101, 1'b0, 5'd9,  1'b0, 1'b1, 2'b00, 4'b0001}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic check_id(input string req, input logic [3:0] exp);
      check(req, iir_id, exp);
      check("R2", irq, exp != 4'b0001);
   endtask

   initial begin
      #800000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R10 watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      // R10 reset state
      check_id("R10", 4'b0001);
      check("R10", {rx_fifo_clr, tx_fifo_clr, rx_dma_evt, tx_dma_evt}, 4'b0);
      rst_n = 1'b1;
      step();
      thr_empty = 1'b1;
      step();
      check("R10", tx_dma_evt, 1'b0); // FIFO and DMA mode off after reset

      // table: priority, enables, trigger depths (R1 R3 R5)
      for (int i = 0; i < 12; i++) begin
         {ie_line, ie_rx, ie_tx} = VEC[i][16:14];
         rx_count  = VEC[i][12:8];
         thr_empty = VEC[i][7];
         fcr_wr    = 1'b1;
         fcr_data  = {VEC[i][5:4], 5'b00000, VEC[i][6]};
         lsr_rd    = 1'b1;
         thr_wr    = 1'b1;
         step();
         fcr_wr = 0; lsr_rd = 0; thr_wr = 0;
         line_err_set = VEC[i][13] ? 4'b0100 : 4'b0000;
         step();
         line_err_set = '0;
         step();
         check_id($sformatf("R1/R3/R5 vec%0d", i), VEC[i][3:0]);
      end

      // R4: flag sticky, cleared by line status read
      ie_line = 1; ie_rx = 0; ie_tx = 0; rx_count = '0; thr_empty = 0;
      line_err_set = 4'b0001; step(); line_err_set = '0;
      repeat (3) step();
      check_id("R4 sticky", 4'b0110);
      lsr_rd = 1; step(); lsr_rd = 0;
      check_id("R4 cleared", 4'b0001);

      // R7: read while line error outranks leaves THRE pending
      ie_tx = 1; thr_empty = 1;
      line_err_set = 4'b1000; step(); line_err_set = '0;
      check_id("R7 line first", 4'b0110);
      iir_rd = 1; step(); iir_rd = 0;
      lsr_rd = 1; step(); lsr_rd = 0;
      check_id("R7 thre kept", 4'b0010);
      iir_rd = 1; step(); iir_rd = 0;
      check_id("R7 thre acked", 4'b0001);
      step();
      check_id("R7 stays acked", 4'b0001);
      thr_wr = 1; step(); thr_wr = 0;
      check_id("R7 rearmed", 4'b0010);
      ie_tx = 0;

      // R6: character timeout
      fcr_wr = 1; fcr_data = 8'hC1; step(); fcr_wr = 0;
      ie_rx = 1; rx_count = 5'd2;
      for (int k = 0; k < 3; k++) begin
         char_tick = 1; step(); char_tick = 0; step();
      end
      check_id("R6 three ticks", 4'b0001);
      rx_push = 1; step(); rx_push = 0; rx_count = 5'd3;
      for (int k = 0; k < 3; k++) begin
         char_tick = 1; step(); char_tick = 0; step();
      end
      check_id("R6 push restarts", 4'b0001);
      char_tick = 1; step(); char_tick = 0;
      check_id("R6 fourth tick", 4'b1100);
      rx_pop = 1; step(); rx_pop = 0; rx_count = 5'd2;
      check_id("R6 pop clears", 4'b0001);

      // R8: flush pulses one cycle after write
      fcr_wr = 1; fcr_data = 8'h06; step(); fcr_wr = 0;
      check("R8 rx clr", rx_fifo_clr, 1'b1);
      check("R8 tx clr", tx_fifo_clr, 1'b1);
      step();
      check("R8 clr ends", {rx_fifo_clr, tx_fifo_clr}, 2'b00);

      // R9: DMA events
      ie_rx = 0; rx_count = 5'd0; thr_empty = 0;
      fcr_wr = 1; fcr_data = 8'h49; step(); fcr_wr = 0; // fifo, dma, depth 4
      step();
      rx_count = 5'd4; step();
      check("R9 rx evt", rx_dma_evt, 1'b1);
      step();
      check("R9 rx evt single", rx_dma_evt, 1'b0);
      thr_empty = 1; step();
      check("R9 tx evt", tx_dma_evt, 1'b1);
      step();
      check("R9 tx evt single", tx_dma_evt, 1'b0);
      rx_count = 0; thr_empty = 0;
      fcr_wr = 1; fcr_data = 8'h41; step(); fcr_wr = 0; // dma off
      step();
      rx_count = 5'd4; thr_empty = 1; step();
      check("R9 no evt without dma", {rx_dma_evt, tx_dma_evt}, 2'b00);
      step();
      check("R9 no evt without dma", {rx_dma_evt, tx_dma_evt}, 2'b00);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule